// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits on the host side of an 8K x 8 asynchronous static RAM. It takes one command at a time from a clocked host, either a read or a write of one byte, and turns it into the chip-enable, output-enable, write-enable, address and data pin activity that the memory needs. Every timing interval the memory demands is supplied as a nanosecond parameter. The block converts each one to whole clock cycles by rounding up, using the clock period parameter.

The host holds `req_valid` high together with a stable command until `rsp_done` pulses for one cycle. A command is taken only while the sequencer is idle and `rsp_done` is low. This means a request that is still present in the cycle of the done pulse is started one cycle later. A read returns its byte on `rsp_rdata`, and the byte stays there until the next read completes. The shared data pins are split into an input, an output and a drive-enable. Wiring them to a real pad is left to the chip level.

Top module: `sram_seq`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are 1, `mem_dq_oe` is 0, `rsp_done` is 0 and `rsp_rdata` is 0.
- R2: In a read, `mem_ce_n` and `mem_oe_n` fall together in the cycle after acceptance, with the address already on `mem_addr`. They stay low for the larger of the address, chip-enable and output-enable access times, rounded up to cycles (5 cycles at the defaults: 100, 100 and 50 ns at 20 ns). The memory byte is captured at the edge where they rise.
- R3: In a write, `mem_ce_n` and `mem_we_n` fall together with the address change, and `mem_oe_n` stays 1 throughout. `mem_we_n` stays low for the largest of the pulse width, the address-to-rise time and the data setup time, rounded up (4 cycles at the defaults: 80, 80 and 50 ns).
- R4: `mem_dq_oe` is 1 only during a write, from the falling edge of `mem_we_n` to the end of the hold phase (5 cycles at the defaults). It is never 1 while `mem_oe_n` is 0.
- R5: After `mem_we_n` rises, `mem_addr` and `mem_dq_out` keep their values and `mem_dq_oe` stays 1 for the larger of the data hold and address hold times, rounded up and at least one cycle (1 cycle at the defaults: 5 and 10 ns).
- R6: After `mem_oe_n` rises at the end of a read, the sequencer waits at least the output float time before it drives data (2 cycles at 40 ns). This recovery also pads the whole cycle to at least the 100 ns cycle time. A read completes 8 clock edges after the request is first presented at the defaults.
- R7: `rsp_done` is a single-cycle pulse. A write completes 6 clock edges after its request is first presented at the defaults.
- R8: With `req_valid` low, no pin leaves its idle level. A request that is present while `rsp_done` is 1 starts one cycle later, so its latency grows by one edge.
- R9: All 8,192 addresses of the 13-bit space map to distinct bytes. `rsp_rdata` changes only when a read captures data, and a write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Command present, held until `rsp_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte address |
| req_wdata | input | 8 | Byte to write |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte from the last completed read |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 13 | Memory address pins |
| mem_dq_out | output | 8 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 8 | Data from the memory |

## Verification
The bench builds the block with its default parameters: a 20 ns clock and the nanosecond limits above. These round up to 5 access cycles, 2 recovery cycles, 4 write-enable cycles and 1 hold cycle. None of these counts is 1 except the hold, so a shortened access or pulse is caught by the behavioural memory. That memory returns valid data only after five full cycles of enable, and it commits writes on the rising edge of write enable. The defaults also make the highest address 8191 and address 0 reachable directly. A read followed immediately by a write exercises the output-float turnaround and the one-cycle restart gap.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_ACC  = 3'd1,
    ST_RD_REC  = 3'd2,
    ST_WR_LOW  = 3'd3,
    ST_WR_HOLD = 3'd4
  } seq_state_e;

  // Ceiling division of a nanosecond limit by the clock period.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int RD_ACC_CYC  = 5,
  parameter int RD_REC_CYC  = 2,
  parameter int WR_LOW_CYC  = 4,
  parameter int WR_HOLD_CYC = 1,
  parameter int CNT_W       = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       accept,
  output logic       capture,
  output logic       done_q
);

  localparam logic [CNT_W-1:0] RD_ACC_LD  = CNT_W'(RD_ACC_CYC - 1);
  localparam logic [CNT_W-1:0] RD_REC_LD  = CNT_W'(RD_REC_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LOW_LD  = CNT_W'(WR_LOW_CYC - 1);
  localparam logic [CNT_W-1:0] WR_HOLD_LD = CNT_W'(WR_HOLD_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             done_d;
  logic             last;

  // Next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    accept  = 1'b0;
    capture = 1'b0;
    last    = (cnt_q == '0);
    if (!last) cnt_d = cnt_q - 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req_valid && !done_q) begin
          accept = 1'b1;
          if (req_write) begin
            state_d = ST_WR_LOW;
            cnt_d   = WR_LOW_LD;
          end else begin
            state_d = ST_RD_ACC;
            cnt_d   = RD_ACC_LD;
          end
        end
      end
      ST_RD_ACC: begin
        if (last) begin
          capture = 1'b1;
          state_d = ST_RD_REC;
          cnt_d   = RD_REC_LD;
        end
      end
      ST_RD_REC: begin
        if (last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      ST_WR_LOW: begin
        if (last) begin
          state_d = ST_WR_HOLD;
          cnt_d   = WR_HOLD_LD;
        end
      end
      ST_WR_HOLD: begin
        if (last) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  // R7: completion is a single-cycle pulse
  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8: an accepted command always leaves the idle state on the next edge
  assert_accept_leaves_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (state_q != ST_IDLE));

endmodule

// File: rtl/sram_seq_pins.sv
module sram_seq_pins
  import sram_seq_pkg::*;
#(
  parameter int RD_ACC_CYC   = 5,
  parameter int WR_LOW_CYC   = 4,
  parameter int OE_FLOAT_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seq_state_e state_d,
  output logic       ce_n,
  output logic       oe_n,
  output logic       we_n,
  output logic       dq_oe
);

  logic ce_nx, oe_nx, we_nx, dq_oe_x;

  // Pin levels follow the next state so that they change on the same edge
  always_comb begin
    ce_nx   = !((state_d == ST_RD_ACC) || (state_d == ST_WR_LOW));
    oe_nx   = (state_d != ST_RD_ACC);
    we_nx   = (state_d != ST_WR_LOW);
    dq_oe_x = (state_d == ST_WR_LOW) || (state_d == ST_WR_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= ce_nx;
      oe_n  <= oe_nx;
      we_n  <= we_nx;
      dq_oe <= dq_oe_x;
    end
  end

  // Checker counters for pulse widths and turnaround
  logic [7:0] oe_low_cnt, we_low_cnt, oe_high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_low_cnt  <= '0;
      we_low_cnt  <= '0;
      oe_high_cnt <= '0;
    end else begin
      oe_low_cnt  <= oe_n ? 8'd0 : oe_low_cnt + 8'd1;
      we_low_cnt  <= we_n ? 8'd0 : we_low_cnt + 8'd1;
      if (!oe_n)                   oe_high_cnt <= '0;
      else if (oe_high_cnt != '1)  oe_high_cnt <= oe_high_cnt + 8'd1;
    end
  end

  assert_oe_low_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_n) |-> (oe_low_cnt == 8'(RD_ACC_CYC)));

  assert_we_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_low_cnt == 8'(WR_LOW_CYC)));

  assert_oe_off_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> oe_n);

  assert_ce_with_we_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !ce_n);

  assert_no_drive_while_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  assert_data_held_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe);

  assert_float_before_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> (oe_high_cnt >= 8'(OE_FLOAT_CYC)));

endmodule

// File: rtl/sram_seq_data.sv
module sram_seq_data #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] rdata_q
);

  logic addr_en, rdata_en;

  assign addr_en  = accept;
  assign rdata_en = capture;

  // Address and write byte are held for the whole command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (addr_en) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= mem_dq_in;
  end

  // R9: returned byte moves only on a capture
  assert_rdata_only_on_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_q) |-> $past(capture));

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W          = 13,
  parameter int DATA_W          = 8,
  parameter int CLK_NS          = 20,
  parameter int T_CYCLE_NS      = 100,
  parameter int T_ADDR_ACC_NS   = 100,
  parameter int T_CE_ACC_NS     = 100,
  parameter int T_OE_ACC_NS     = 50,
  parameter int T_OE_FLOAT_NS   = 40,
  parameter int T_WE_LOW_NS     = 80,
  parameter int T_ADDR_WE_NS    = 80,
  parameter int T_DATA_SETUP_NS = 50,
  parameter int T_DATA_HOLD_NS  = 5,
  parameter int T_ADDR_HOLD_NS  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int CYC_RC  = ns_to_cyc(T_CYCLE_NS, CLK_NS);
  localparam int CYC_AA  = ns_to_cyc(T_ADDR_ACC_NS, CLK_NS);
  localparam int CYC_CA  = ns_to_cyc(T_CE_ACC_NS, CLK_NS);
  localparam int CYC_OA  = ns_to_cyc(T_OE_ACC_NS, CLK_NS);
  localparam int CYC_OHZ = ns_to_cyc(T_OE_FLOAT_NS, CLK_NS);
  localparam int CYC_WP  = ns_to_cyc(T_WE_LOW_NS, CLK_NS);
  localparam int CYC_AW  = ns_to_cyc(T_ADDR_WE_NS, CLK_NS);
  localparam int CYC_DS  = ns_to_cyc(T_DATA_SETUP_NS, CLK_NS);
  localparam int CYC_DH  = ns_to_cyc(T_DATA_HOLD_NS, CLK_NS);
  localparam int CYC_AH  = ns_to_cyc(T_ADDR_HOLD_NS, CLK_NS);

  localparam int RD_ACC_CYC  = imax(imax(CYC_AA, CYC_CA), imax(CYC_OA, 1));
  localparam int RD_REC_CYC  = imax(imax(CYC_OHZ, CYC_RC - RD_ACC_CYC), 1);
  localparam int WR_LOW_CYC  = imax(imax(CYC_WP, CYC_AW), imax(CYC_DS, 1));
  localparam int WR_HOLD_CYC = imax(imax(CYC_DH, CYC_AH), imax(CYC_RC - WR_LOW_CYC, 1));
  localparam int CNT_MAX     = imax(imax(RD_ACC_CYC, RD_REC_CYC), imax(WR_LOW_CYC, WR_HOLD_CYC));
  localparam int CNT_W       = $clog2(CNT_MAX + 1);

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  seq_state_e state_q, state_d;
  logic       accept, capture;

  sram_seq_ctrl #(
    .RD_ACC_CYC  (RD_ACC_CYC),
    .RD_REC_CYC  (RD_REC_CYC),
    .WR_LOW_CYC  (WR_LOW_CYC),
    .WR_HOLD_CYC (WR_HOLD_CYC),
    .CNT_W       (CNT_W)
  ) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .state_q   (state_q),
    .state_d   (state_d),
    .accept    (accept),
    .capture   (capture),
    .done_q    (rsp_done)
  );

  sram_seq_pins #(
    .RD_ACC_CYC   (RD_ACC_CYC),
    .WR_LOW_CYC   (WR_LOW_CYC),
    .OE_FLOAT_CYC (CYC_OHZ)
  ) pins_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .state_d (state_d),
    .ce_n    (mem_ce_n),
    .oe_n    (mem_oe_n),
    .we_n    (mem_we_n),
    .dq_oe   (mem_dq_oe)
  );

  sram_seq_data #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) data_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_in (mem_dq_in),
    .addr_q    (mem_addr),
    .wdata_q   (mem_dq_out),
    .rdata_q   (rsp_rdata)
  );

  // R5: address does not move on the write-enable rising edge
  assert_addr_stable_at_we_rise_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(mem_we_n) |-> $stable(mem_addr));

  // R9: address changes only when a new command starts, never mid-cycle
  assert_addr_moves_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(mem_addr) |-> ($past(state_q) == ST_IDLE));

endmodule

// File: tb/sram_seq_tb_top.sv
module sram_seq_tb_top;

  localparam int AW       = 13;
  localparam int DW       = 8;
  // Expected counts from the requirements at a 20 ns clock
  localparam int ACC_LEN  = 5;   // R2
  localparam int WE_LEN   = 4;   // R3
  localparam int DRV_LEN  = 5;   // R4
  localparam int RD_LAT   = 8;   // R6
  localparam int WR_LAT   = 6;   // R7

  logic          clk;
  logic          rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  sram_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural memory and pin monitor, evaluated at falling edges
  logic [7:0] mem_model [int];
  int acc_cnt = 0, we_cnt = 0, drv_cnt = 0, oe_hi_cnt = 0;
  int last_acc = 0, last_we = 0, last_drv = 0;
  bit we_prev = 1, oe_prev = 1, dq_prev = 0;
  bit hold_ok = 0, contention = 0, oe_in_wr = 0, turn_bad = 0;
  logic [AW-1:0] addr_low;
  logic [DW-1:0] data_low;
  logic [DW-1:0] dq_in_r = 8'h3C;
  assign mem_dq_in = dq_in_r;

  function automatic logic [7:0] mread(input int a);
    if (mem_model.exists(a)) return mem_model[a];
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n && !mem_oe_n) acc_cnt++; else acc_cnt = 0;
      dq_in_r = (acc_cnt >= ACC_LEN) ? mread(int'(mem_addr)) : 8'h3C;
      if (mem_oe_n && !oe_prev) last_acc = acc_prev_len;
      if (!mem_oe_n && mem_dq_oe) contention = 1;
      if (!mem_we_n && !mem_oe_n) oe_in_wr = 1;
      if (mem_oe_n) oe_hi_cnt++; else oe_hi_cnt = 0;
      if (mem_dq_oe && !dq_prev && oe_hi_cnt < 3) turn_bad = 1;
      if (mem_dq_oe) drv_cnt++;
      else if (dq_prev) begin last_drv = drv_cnt; drv_cnt = 0; end
      if (!mem_we_n) begin
        we_cnt++;
        addr_low = mem_addr;
        data_low = mem_dq_out;
      end
      if (mem_we_n && !we_prev) begin
        last_we = we_cnt;
        we_cnt  = 0;
        hold_ok = mem_dq_oe && (mem_addr == addr_low) && (mem_dq_out == data_low);
        mem_model[int'(mem_addr)] = mem_dq_out;
      end
      acc_prev_len = acc_cnt;
      we_prev = mem_we_n; oe_prev = mem_oe_n; dq_prev = mem_dq_oe;
    end
  end
  int acc_prev_len = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input bit skip_gap, output int lat, output logic [DW-1:0] rd);
    if (!skip_gap) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!rsp_done && lat < 100);
    req_valid = 1'b0;
    #2;
    rd = rsp_rdata;
  endtask

  task automatic t_reset;
    chk(mem_ce_n == 1'b1, "R1 ce_n idle", mem_ce_n, 1);
    chk(mem_oe_n == 1'b1, "R1 oe_n idle", mem_oe_n, 1);
    chk(mem_we_n == 1'b1, "R1 we_n idle", mem_we_n, 1);
    chk(mem_dq_oe == 1'b0, "R1 dq_oe idle", mem_dq_oe, 0);
    chk(rsp_done == 1'b0, "R1 done idle", rsp_done, 0);
    chk(rsp_rdata == 8'h00, "R1 rdata reset", rsp_rdata, 0);
  endtask

  task automatic t_idle;
    int bad = 0;
    req_valid = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); #1;
      if (!mem_ce_n || !mem_oe_n || !mem_we_n || mem_dq_oe || rsp_done) bad++;
    end
    chk(bad == 0, "R8 idle without request", bad, 0);
  endtask

  task automatic t_write_read(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat;
    logic [DW-1:0] rd;
    do_op(1'b1, a, d, 1'b0, lat, rd);
    chk(lat == WR_LAT, "R7 write latency", lat, WR_LAT);
    chk(last_we == WE_LEN, "R3 we_n low width", last_we, WE_LEN);
    chk(last_drv == DRV_LEN, "R4 drive window", last_drv, DRV_LEN);
    chk(hold_ok, "R5 hold after we_n rise", hold_ok, 1);
    do_op(1'b0, a, 8'h00, 1'b0, lat, rd);
    chk(lat == RD_LAT, "R6 read latency", lat, RD_LAT);
    chk(last_acc == ACC_LEN, "R2 access width", last_acc, ACC_LEN);
    chk(rd == d, "R2 read data", rd, d);
  endtask

  task automatic t_back_to_back;
    int lat;
    logic [DW-1:0] rd;
    do_op(1'b1, 13'h0ABC, 8'h96, 1'b0, lat, rd);
    do_op(1'b0, 13'h0ABC, 8'h00, 1'b0, lat, rd);
    // next request presented in the same cycle as the done pulse
    do_op(1'b1, 13'h0ABD, 8'h69, 1'b1, lat, rd);
    chk(lat == WR_LAT + 1, "R8 restart gap after done", lat, WR_LAT + 1);
    chk(rd == 8'h96, "R9 rdata kept across write", rd, 8'h96);
    do_op(1'b0, 13'h0ABD, 8'h00, 1'b1, lat, rd);
    chk(lat == RD_LAT + 1, "R8 read after done", lat, RD_LAT + 1);
    chk(rd == 8'h69, "R9 neighbour byte", rd, 8'h69);
  endtask

  task automatic t_distinct;
    int lat;
    logic [DW-1:0] rd;
    do_op(1'b0, 13'h1FFF, 8'h00, 1'b0, lat, rd);
    chk(rd == 8'hA5, "R9 top address kept", rd, 8'hA5);
    do_op(1'b0, 13'h0000, 8'h00, 1'b0, lat, rd);
    chk(rd == 8'h5A, "R9 bottom address kept", rd, 8'h5A);
  endtask

  task automatic t_flags;
    chk(!contention, "R4 no drive with oe_n low", contention, 0);
    chk(!oe_in_wr, "R3 oe_n high in write", oe_in_wr, 0);
    chk(!turn_bad, "R6 float time before drive", turn_bad, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    t_reset();
    t_idle();
    t_write_read(13'h0000, 8'h5A);
    t_write_read(13'h1FFF, 8'hA5);
    t_write_read(13'h1555, 8'hFF);
    t_write_read(13'h0AAA, 8'h00);
    t_distinct();
    t_back_to_back();
    t_flags();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule